// File: doc/BRIEF.md
# Push-Button Wake and Reset Controller

This block interprets a debounced, active-low push button for a battery-powered system. While the button is held, one shared tick counter measures the press. It is compared against four programmable expiry points: a first wake point, a second wake point, a reset-warning point and a long-press point. Each expiry raises a sticky flag and a one-cycle interrupt request. The long-press expiry also carries out a configurable action: nothing, entry to the low-power ship state, or a power cycle of the system rail.

The block also controls the exit from ship state. In ship state, only the first wake point matters. Holding the button until that point turns the system rail back on, and the optional regulator with it when that regulator is configured on. Releasing the button earlier leaves the block in ship state. A valid input supply ends ship state at once. After any exit from ship state with the button still held, the press is treated as spent: the button has to be released and pressed again before it can do anything more.

All durations are counted in ticks of the `tick` enable. Each duration is captured when a press starts, so a value rewritten during a press only takes effect once that timer has expired or the button has been released.

Top module: `btn_wake_ctrl`

## Requirements
- R1: A press is recognised only while `batt_ok` is 1. When `batt_ok` is 0 the press counter is held at zero and no flag, interrupt or action results.
- R2: With the button held and armed, the first-wake flag (`flags[0]`) is set on the Nth counted tick, where N is `wake1_dur`, and `irq` pulses for one cycle. A duration of 0 disables that timer.
- R3: The second wake point (`wake2_dur`) sets `flags[1]` and pulses `irq`. It has no effect on the rail, on ship state or on the other timers, and it is ignored while in ship state.
- R4: In ship state, a press held for `wake1_dur` ticks leaves ship state. `rail_en` goes to 1, `reg_en` follows `reg_cfg_en`, and `flags[0]` is set.
- R5: In ship state, a press released before `wake1_dur` ticks leaves the block in ship state with `rail_en` and `reg_en` at 0.
- R6: In ship state, `vin_ok` = 1 ends ship state on the next clock edge, whatever the button or timer state.
- R7: If the button is still held when ship state ends, no further flag, interrupt or long-press action comes from that press. The next release followed by a press works normally.
- R8: The warning flag (`flags[2]`) is set after `lpress_dur - warn_lead` ticks. When `warn_lead` is at least `lpress_dur`, it is set after 1 tick. When `lpress_dur` is 0, it is never set.
- R9: When the press reaches `lpress_dur` ticks outside ship state, the latched action is taken on that edge. Action code 00 does nothing, 01 enters ship state, 10 power-cycles the rail, and 11 does nothing. The press then needs a release before it counts again.
- R10: A duration written while its timer is running does not affect that press. It applies once that timer has expired or the button has been released.
- R11: While the button is held, a new `lpress_act` value is taken up, except a change to the power-cycle code, which is refused until release.
- R12: A power-cycle action holds `rail_en` (and `reg_en`) at 0 for `CYCLE_TICKS` ticks and then sets them again.
- R13: Flags stay set until cleared through the matching `flag_clr` bit; a set on the same edge wins over a clear. `irq` pulses only when a flag goes from clear to set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timebase enable; one count per cycle where high |
| btn_n | input | 1 | Debounced button, 0 = pressed |
| batt_ok | input | 1 | Battery above undervoltage level |
| vin_ok | input | 1 | Valid input supply present |
| reg_cfg_en | input | 1 | Optional regulator configured on |
| wake1_dur | input | TW | First wake duration in ticks |
| wake2_dur | input | TW | Second wake duration in ticks |
| lpress_dur | input | TW | Long-press duration in ticks |
| warn_lead | input | TW | Warning lead before long press, in ticks |
| lpress_act | input | 2 | Long-press action code |
| flag_clr | input | 3 | Per-flag clear strobe |
| flags | output | 3 | Sticky flags: [0] wake1, [1] wake2, [2] warning |
| irq | output | 1 | One-cycle interrupt request |
| rail_en | output | 1 | System rail enable |
| reg_en | output | 1 | Optional regulator enable |
| in_ship | output | 1 | Block is in ship state |

## Verification
The bench targets the exact tick on which each expiry lands, since a design with an off-by-one compare would flag one tick early or late. It rewrites a duration in the middle of a press; a design without captured durations would move the expiry. It holds the button through an exit from ship state, where a design that does not disarm would drop straight back into ship state at the long-press point. It also tries to upgrade the action to a power cycle during a press, which a design without the restriction would carry out, giving a visible dip on the rail.

// File: rtl/bw_pkg.sv
`timescale 1ns/1ps
package bw_pkg;
  typedef enum logic [1:0] {
    PS_ON    = 2'd0,
    PS_SHIP  = 2'd1,
    PS_CYCLE = 2'd2
  } pwr_st_e;

  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_SHIP  = 2'd1,
    ACT_CYCLE = 2'd2,
    ACT_RSVD  = 2'd3
  } lp_act_e;

  localparam int NUM_TMR  = 4;
  localparam int NUM_FLAG = 3;
  localparam int TI_WAKE1 = 0;
  localparam int TI_WAKE2 = 1;
  localparam int TI_WARN  = 2;
  localparam int TI_LONG  = 3;
endpackage

// File: rtl/bw_press_stage.sv
`timescale 1ns/1ps
module bw_press_stage #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pressed,
  input  logic          step,
  input  logic [TW-1:0] cnt_nxt,
  input  logic [TW-1:0] dur_in,
  output logic          hit
);
  logic [TW-1:0] dur_q;
  logic          done_q;

  // a duration of zero never matches because cnt_nxt is at least 1
  assign hit = step && !done_q && (cnt_nxt == dur_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dur_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (!pressed || done_q) dur_q <= dur_in;
      if (!pressed)           done_q <= 1'b0;
      else if (hit)           done_q <= 1'b1;
    end
  end
endmodule

// File: rtl/bw_flag_bank.sv
`timescale 1ns/1ps
module bw_flag_bank #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ev,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags,
  output logic         irq
);
  logic [N-1:0] flags_q;
  logic         irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      flags_q <= (flags_q & ~clr) | ev;
      irq_q   <= |(ev & ~flags_q);
    end
  end

  assign flags = flags_q;
  assign irq   = irq_q;
endmodule

// File: rtl/bw_power_fsm.sv
`timescale 1ns/1ps
module bw_power_fsm
  import bw_pkg::*;
#(
  parameter int CYCLE_TICKS = 4
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    tick,
  input  logic    vin_ok,
  input  logic    ev_w1,
  input  logic    ev_lp,
  input  lp_act_e act,
  output pwr_st_e state,
  output logic    exit_ship
);
  localparam int CW = $clog2(CYCLE_TICKS) + 1;
  localparam logic [CW-1:0] CYC_LAST = CW'(CYCLE_TICKS - 1);

  pwr_st_e       state_q;
  logic [CW-1:0] cyc_q;

  assign exit_ship = (state_q == PS_SHIP) && (vin_ok || ev_w1);
  assign state     = state_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= PS_ON;
      cyc_q   <= '0;
    end else begin
      unique case (state_q)
        PS_ON: begin
          if (ev_lp && act == ACT_SHIP) state_q <= PS_SHIP;
          else if (ev_lp && act == ACT_CYCLE) begin
            state_q <= PS_CYCLE;
            cyc_q   <= '0;
          end
        end
        PS_SHIP: if (exit_ship) state_q <= PS_ON;
        PS_CYCLE: begin
          if (tick) begin
            if (cyc_q == CYC_LAST) state_q <= PS_ON;
            else                   cyc_q   <= cyc_q + 1'b1;
          end
        end
        default: state_q <= PS_ON;
      endcase
    end
  end
endmodule

// File: rtl/btn_wake_ctrl.sv
`timescale 1ns/1ps
module btn_wake_ctrl
  import bw_pkg::*;
#(
  parameter int TW          = 8,
  parameter int CYCLE_TICKS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          btn_n,
  input  logic          batt_ok,
  input  logic          vin_ok,
  input  logic          reg_cfg_en,
  input  logic [TW-1:0] wake1_dur,
  input  logic [TW-1:0] wake2_dur,
  input  logic [TW-1:0] lpress_dur,
  input  logic [TW-1:0] warn_lead,
  input  logic [1:0]    lpress_act,
  input  logic [2:0]    flag_clr,
  output logic [2:0]    flags,
  output logic          irq,
  output logic          rail_en,
  output logic          reg_en,
  output logic          in_ship
);
  localparam logic [TW-1:0] CNT_MAX = '1;

  // warning point: lead before the long press, at least one tick, none if disabled
  function automatic logic [TW-1:0] warn_point(input logic [TW-1:0] lp,
                                               input logic [TW-1:0] lead);
    if (lp == '0)        return '0;
    else if (lp > lead)  return lp - lead;
    else                 return TW'(1);
  endfunction

  // named internal events, used by the bound checker
  logic          pressed;
  logic          armed_q;
  logic [TW-1:0] cnt_q;
  logic [TW-1:0] cnt_nxt;
  logic          step;
  logic          ev_w1, ev_w2, ev_warn, ev_lp;
  logic          exit_ship;
  lp_act_e       act_q;
  pwr_st_e       state;
  logic [TW-1:0] dur_vec [NUM_TMR];
  logic [NUM_TMR-1:0] hit;

  assign pressed = !btn_n && batt_ok;
  assign step    = pressed && armed_q && tick && (cnt_q != CNT_MAX);
  assign cnt_nxt = cnt_q + 1'b1;

  assign dur_vec[TI_WAKE1] = wake1_dur;
  assign dur_vec[TI_WAKE2] = wake2_dur;
  assign dur_vec[TI_WARN]  = warn_point(lpress_dur, warn_lead);
  assign dur_vec[TI_LONG]  = lpress_dur;

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_stage
    bw_press_stage #(.TW(TW)) u_stage (
      .clk    (clk),
      .rst_n  (rst_n),
      .pressed(pressed),
      .step   (step),
      .cnt_nxt(cnt_nxt),
      .dur_in (dur_vec[g]),
      .hit    (hit[g])
    );
  end

  assign ev_w1   = hit[TI_WAKE1] && (state != PS_CYCLE);
  assign ev_w2   = hit[TI_WAKE2] && (state == PS_ON);
  assign ev_warn = hit[TI_WARN]  && (state == PS_ON);
  assign ev_lp   = hit[TI_LONG]  && (state == PS_ON);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b1;
      act_q   <= ACT_NONE;
    end else begin
      if (!pressed)  cnt_q <= '0;
      else if (step) cnt_q <= cnt_nxt;

      if (!pressed)                  armed_q <= 1'b1;
      else if (exit_ship || ev_lp)   armed_q <= 1'b0;

      if (!pressed || lp_act_e'(lpress_act) != ACT_CYCLE)
        act_q <= lp_act_e'(lpress_act);
    end
  end

  bw_power_fsm #(.CYCLE_TICKS(CYCLE_TICKS)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .vin_ok   (vin_ok),
    .ev_w1    (ev_w1),
    .ev_lp    (ev_lp),
    .act      (act_q),
    .state    (state),
    .exit_ship(exit_ship)
  );

  bw_flag_bank #(.N(NUM_FLAG)) u_flags (
    .clk  (clk),
    .rst_n(rst_n),
    .ev   ({ev_warn, ev_w2, ev_w1}),
    .clr  (flag_clr),
    .flags(flags),
    .irq  (irq)
  );

  assign rail_en = (state == PS_ON);
  assign reg_en  = rail_en && reg_cfg_en;
  assign in_ship = (state == PS_SHIP);
endmodule

// File: rtl/bw_chk.sv
`timescale 1ns/1ps
module bw_chk
  import bw_pkg::*;
#(
  parameter int TW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          batt_ok,
  input logic          vin_ok,
  input logic          pressed,
  input logic          armed_q,
  input logic [TW-1:0] cnt_q,
  input logic          ev_w1,
  input logic          ev_w2,
  input logic          ev_lp,
  input logic          exit_ship,
  input lp_act_e       act_q,
  input logic [2:0]    flags,
  input logic          irq,
  input logic          rail_en,
  input logic          in_ship
);
  a_r1_batt_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !batt_ok |=> (cnt_q == '0));

  a_r2_wake1_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ev_w1 |=> flags[0]);

  a_r3_wake2_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_w2 && !ev_lp) |=> (rail_en && !in_ship));

  a_r4_ship_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ship && ev_w1) |=> rail_en);

  a_r5_ship_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ship && !pressed && !vin_ok) |=> in_ship);

  a_r6_vin_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ship && vin_ok) |=> !in_ship);

  a_r7_disarm: assert property (@(posedge clk) disable iff (!rst_n)
    (exit_ship && pressed) |=> !armed_q);

  a_r9_ship_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_lp && act_q == ACT_SHIP) |=> in_ship);

  a_r11_no_cycle_upgrade: assert property (@(posedge clk) disable iff (!rst_n)
    (pressed && act_q != ACT_CYCLE) |=> (act_q != ACT_CYCLE));

  a_r12_cycle_low: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rail_en) && !in_ship) |=> !rail_en);

  a_r13_irq_new_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> |(flags & ~$past(flags)));
endmodule

bind btn_wake_ctrl bw_chk #(.TW(TW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .batt_ok  (batt_ok),
  .vin_ok   (vin_ok),
  .pressed  (pressed),
  .armed_q  (armed_q),
  .cnt_q    (cnt_q),
  .ev_w1    (ev_w1),
  .ev_w2    (ev_w2),
  .ev_lp    (ev_lp),
  .exit_ship(exit_ship),
  .act_q    (act_q),
  .flags    (flags),
  .irq      (irq),
  .rail_en  (rail_en),
  .in_ship  (in_ship)
);

// File: tb/btn_wake_ctrl_test.sv
`timescale 1ns/1ps
module btn_wake_ctrl_test;
  localparam int TW = 8;
  localparam int CYC = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          tick, btn_n, batt_ok, vin_ok, reg_cfg_en;
  logic [TW-1:0] wake1_dur, wake2_dur, lpress_dur, warn_lead;
  logic [1:0]    lpress_act;
  logic [2:0]    flag_clr;
  logic [2:0]    flags;
  logic          irq, rail_en, reg_en, in_ship;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;

  btn_wake_ctrl #(.TW(TW), .CYCLE_TICKS(CYC)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .btn_n(btn_n), .batt_ok(batt_ok),
    .vin_ok(vin_ok), .reg_cfg_en(reg_cfg_en), .wake1_dur(wake1_dur),
    .wake2_dur(wake2_dur), .lpress_dur(lpress_dur), .warn_lead(warn_lead),
    .lpress_act(lpress_act), .flag_clr(flag_clr), .flags(flags), .irq(irq),
    .rail_en(rail_en), .reg_en(reg_en), .in_ship(in_ship)
  );

  // vector: wake1, wake2, hold ticks, expected flags after release
  typedef struct packed {
    logic [7:0] w1;
    logic [7:0] w2;
    logic [7:0] hold;
    logic [2:0] exp_flags;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    {8'd3, 8'd6, 8'd2,  3'b000},
    {8'd3, 8'd6, 8'd3,  3'b001},
    {8'd3, 8'd6, 8'd6,  3'b011},
    {8'd5, 8'd2, 8'd4,  3'b010},
    {8'd0, 8'd4, 8'd10, 3'b010},
    {8'd1, 8'd1, 8'd1,  3'b011}
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear_flags();
    flag_clr = 3'b111;
    step(1);
    flag_clr = 3'b000;
  endtask

  task automatic release_btn();
    btn_n = 1'b1;
    step(1);
  endtask

  initial begin : watchdog
    #(4 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    rst_n = 1'b0; tick = 1'b1; btn_n = 1'b1; batt_ok = 1'b1; vin_ok = 1'b0;
    reg_cfg_en = 1'b1; wake1_dur = 8'd3; wake2_dur = 8'd6; lpress_dur = 8'd200;
    warn_lead = 8'd5; lpress_act = 2'b00; flag_clr = 3'b000;
    step(3);
    rst_n = 1'b1;
    step(1);

    // reset state
    check("reset rail_en", 32'(rail_en), 32'd1);
    check("reset reg_en", 32'(reg_en), 32'd1);
    check("reset in_ship", 32'(in_ship), 32'd0);
    check("reset flags", 32'(flags), 32'd0);
    check("reset irq", 32'(irq), 32'd0);

    // vector table: R2 and R3 expiry points
    for (int i = 0; i < NV; i++) begin
      wake1_dur = VECS[i].w1;
      wake2_dur = VECS[i].w2;
      step(1);
      clear_flags();
      btn_n = 1'b0;
      step(int'(VECS[i].hold));
      release_btn();
      check($sformatf("R2/R3 vector %0d flags", i), 32'(flags), 32'(VECS[i].exp_flags));
      check($sformatf("R3 vector %0d rail", i), 32'(rail_en), 32'd1);
    end

    // R2 and R13: interrupt timing and one pulse per clear-to-set
    wake1_dur = 8'd3; wake2_dur = 8'd0;
    step(1);
    clear_flags();
    btn_n = 1'b0;
    step(2);
    check("R2 irq before expiry", 32'(irq), 32'd0);
    step(1);
    check("R2 irq at expiry", 32'(irq), 32'd1);
    check("R2 flag at expiry", 32'(flags[0]), 32'd1);
    step(1);
    check("R13 irq single pulse", 32'(irq), 32'd0);
    release_btn();
    btn_n = 1'b0;
    step(3);
    check("R13 no irq while flag set", 32'(irq), 32'd0);
    release_btn();
    flag_clr = 3'b010;
    step(1);
    flag_clr = 3'b000;
    check("R13 clearing other bit keeps flag0", 32'(flags), 32'b001);
    clear_flags();
    check("R13 flags cleared", 32'(flags), 32'd0);

    // R1: battery low masks the press
    batt_ok = 1'b0;
    btn_n = 1'b0;
    step(10);
    release_btn();
    check("R1 no flag with battery low", 32'(flags), 32'd0);
    batt_ok = 1'b1;

    // R10: duration rewritten mid-press is deferred
    wake1_dur = 8'd3;
    step(1);
    btn_n = 1'b0;
    step(1);
    wake1_dur = 8'd8;
    step(2);
    check("R10 old duration used", 32'(flags[0]), 32'd1);
    release_btn();
    clear_flags();
    btn_n = 1'b0;
    step(3);
    check("R10 new duration not yet", 32'(flags[0]), 32'd0);
    step(5);
    check("R10 new duration reached", 32'(flags[0]), 32'd1);
    release_btn();
    clear_flags();

    // R8 warning point, R9 action none
    wake1_dur = 8'd0; wake2_dur = 8'd0; lpress_dur = 8'd10; warn_lead = 8'd3;
    step(1);
    btn_n = 1'b0;
    step(6);
    check("R8 warn not early", 32'(flags[2]), 32'd0);
    step(1);
    check("R8 warn at lp-lead", 32'(flags), 32'b100);
    step(5);
    check("R9 action none keeps rail", 32'(rail_en), 32'd1);
    check("R9 action none no ship", 32'(in_ship), 32'd0);
    release_btn();
    clear_flags();

    // R8: lead not below duration gives one tick
    warn_lead = 8'd12;
    step(1);
    btn_n = 1'b0;
    step(1);
    check("R8 lead saturates to one tick", 32'(flags[2]), 32'd1);
    release_btn();
    clear_flags();
    warn_lead = 8'd3;

    // R9: long press enters ship
    lpress_act = 2'b01;
    step(1);
    btn_n = 1'b0;
    step(9);
    check("R9 not yet ship", 32'(in_ship), 32'd0);
    step(1);
    check("R9 ship entered", 32'(in_ship), 32'd1);
    check("R9 rail off", 32'(rail_en), 32'd0);
    check("R9 reg off", 32'(reg_en), 32'd0);
    release_btn();
    clear_flags();

    // R5: early release stays in ship
    wake1_dur = 8'd5; wake2_dur = 8'd8;
    step(1);
    btn_n = 1'b0;
    step(3);
    release_btn();
    check("R5 still ship", 32'(in_ship), 32'd1);
    check("R5 rail off", 32'(rail_en), 32'd0);
    check("R5 no flag", 32'(flags[0]), 32'd0);

    // R4: full hold wakes, R7: held press is spent
    btn_n = 1'b0;
    step(4);
    check("R4 not yet awake", 32'(in_ship), 32'd1);
    step(1);
    check("R4 awake", 32'(in_ship), 32'd0);
    check("R4 rail on", 32'(rail_en), 32'd1);
    check("R4 reg follows cfg", 32'(reg_en), 32'd1);
    check("R4 wake flag", 32'(flags[0]), 32'd1);
    clear_flags();
    step(20);
    check("R7 no ship re-entry while held", 32'(in_ship), 32'd0);
    check("R7 no flags while held", 32'(flags), 32'd0);
    release_btn();
    btn_n = 1'b0;
    step(10);
    check("R7 rearmed press acts", 32'(in_ship), 32'd1);
    release_btn();
    clear_flags();

    // R6: valid supply exits ship while held
    wake1_dur = 8'd50;
    step(1);
    btn_n = 1'b0;
    step(2);
    vin_ok = 1'b1;
    step(1);
    vin_ok = 1'b0;
    check("R6 immediate exit", 32'(in_ship), 32'd0);
    check("R6 rail on", 32'(rail_en), 32'd1);
    step(15);
    check("R7 held after supply exit", 32'(in_ship), 32'd0);
    release_btn();
    clear_flags();

    // R12: power cycle timing
    lpress_act = 2'b10; lpress_dur = 8'd6; wake1_dur = 8'd0; wake2_dur = 8'd0;
    step(1);
    btn_n = 1'b0;
    step(5);
    check("R12 rail before action", 32'(rail_en), 32'd1);
    step(1);
    check("R12 rail dropped", 32'(rail_en), 32'd0);
    check("R12 not ship", 32'(in_ship), 32'd0);
    step(CYC - 1);
    check("R12 rail still low", 32'(rail_en), 32'd0);
    step(1);
    check("R12 rail restored", 32'(rail_en), 32'd1);
    release_btn();
    clear_flags();

    // R11: upgrade to power cycle refused during press
    lpress_act = 2'b00;
    step(1);
    btn_n = 1'b0;
    step(2);
    lpress_act = 2'b10;
    step(6);
    check("R11 no cycle after upgrade", 32'(rail_en), 32'd1);
    step(3);
    check("R11 rail stays on", 32'(rail_en), 32'd1);
    release_btn();

    // R11: change to ship accepted during press
    lpress_act = 2'b00;
    step(1);
    btn_n = 1'b0;
    step(2);
    lpress_act = 2'b01;
    step(4);
    check("R11 ship change accepted", 32'(in_ship), 32'd1);
    release_btn();
    vin_ok = 1'b1;
    step(1);
    vin_ok = 1'b0;
    check("R6 exit with button up", 32'(in_ship), 32'd0);

    // R4 regulator config gate
    reg_cfg_en = 1'b0;
    step(1);
    check("R4 reg gated by cfg", 32'(reg_en), 32'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule